// File: doc/BRIEF.md
# Ring-Checked Set-Associative Translation Buffer

This block translates 32-bit virtual addresses with 4 KB pages through a small set-associative buffer. Each of its ways holds a fixed number of entries; an entry stores a virtual page number, a physical page number, an 8-bit address-space identifier and a 4-bit attribute. A lookup reads one entry from every way at the index given by the low page-number bits and compares all ways in parallel. The matching entry's identifier is mapped to a privilege ring through a packed register that holds one identifier per ring. The block then either produces the physical address, the attribute and a probe word, or reports a fault cause.

Entries are loaded either through a write port, which names the way explicitly, or through a refill port that carries page-table entries fetched by an external walker. The refill port picks the target way itself with a round-robin counter. The result of a lookup is registered and appears one clock after the request.

Top module: `ring_tlb`

## Requirements
- R1: After reset the ring register reads 0x04030201, every entry holds identifier 0 so every lookup misses, and the replacement counter is 0.
- R2: A write to the ring register takes bits [31:8] from the written value and forces bits [7:0] to 0x01.
- R3: A way hits only when its entry at index lk_addr[13:12] (default 4 entries per way; bits [14:12] with 8 entries) holds page number lk_addr[31:12] and a non-zero identifier.
- R4: A lookup with no hit faults with cause 16 for an instruction fetch (lk_kind = 2) and cause 24 for a data access (any other lk_kind).
- R5: A lookup that hits in more than one way faults with cause 17 for a fetch and 25 for a data access.
- R6: The entry's ring is the lowest byte index (byte 0 = bits [7:0]) of the ring register equal to its identifier, or 3 when no byte matches; a ring numerically lower than lk_ring faults with cause 18 for a fetch and 26 for a data access.
- R7: A lookup without fault returns rs_paddr = {entry page, lk_addr[11:0]}, rs_attr = entry attribute and cause 0; a faulting lookup returns zero address, attribute and probe word.
- R8: A write stores page number addr[31:12], physical page pte[31:12], attribute pte[3:0] and, as identifier, the ring register byte selected by pte[5:4], read before the write's clock edge.
- R9: Each refill first increments the replacement counter and writes way (counter + 1) mod the way count, so the first refill after reset goes to way 1.
- R10: A successful lookup returns rs_probe = {lk_addr[31:12], 12'h0} OR the hitting way number OR 0x10 for data accesses and 0x8 for fetches.
- R11: The result appears with rs_valid high exactly one clock after lk_valid, rs_valid is low otherwise, and a lookup sees the contents before any write on the same edge.
- R12: When the write port and the refill port are used in the same cycle, only the write port takes effect; the refill is dropped and the counter does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Virtual address to translate |
| lk_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| lk_ring | input | 2 | Current privilege ring |
| wr_en | input | 1 | Explicit entry write |
| wr_way | input | WAY_W | Way written by the write port |
| wr_addr | input | 32 | Virtual address selecting index and page number |
| wr_pte | input | 32 | Page-table entry for the write port |
| ra_wr | input | 1 | Ring register write strobe |
| ra_data | input | 32 | Ring register write value |
| rf_en | input | 1 | Refill request |
| rf_addr | input | 32 | Virtual address of the refilled page |
| rf_pte | input | 32 | Walked page-table entry |
| ring_asid | output | 32 | Current ring register value |
| rs_valid | output | 1 | Lookup result valid |
| rs_fault | output | 1 | Lookup faulted |
| rs_cause | output | 6 | Fault cause, 0 when no fault |
| rs_paddr | output | 32 | Translated physical address |
| rs_attr | output | 4 | Attribute of the hit entry |
| rs_probe | output | 32 | Probe word of the hit |

## Verification
The assertions watch, on every cycle, that the result strobe follows the request by one clock, that an empty hit vector always becomes a miss cause and a vector with more than one bit becomes a multi-hit cause, that ring register writes keep the forced low byte, and that the replacement counter moves only on an accepted refill. Which way a refill lands in, the identifier captured from the ring register at write time, the lowest-byte ring rule after the register is rewritten, the probe word contents and the precedence of the write port over a simultaneous refill only show up in the bench's directed and random scenarios, compared against its reference model.

// File: rtl/ring_tlb_pkg.sv
package ring_tlb_pkg;
  localparam int VA_W      = 32;
  localparam int PAGE_BITS = 12;
  localparam int VPN_W     = VA_W - PAGE_BITS;
  localparam int ASID_W    = 8;
  localparam int ATTR_W    = 4;
  localparam int CAUSE_W   = 6;
  localparam int RINGS     = 4;

  localparam logic [1:0] KIND_FETCH = 2'd2;

  localparam logic [CAUSE_W-1:0] CAUSE_I_MISS  = 6'd16;
  localparam logic [CAUSE_W-1:0] CAUSE_I_MULTI = 6'd17;
  localparam logic [CAUSE_W-1:0] CAUSE_I_PRIV  = 6'd18;
  localparam logic [CAUSE_W-1:0] CAUSE_D_MISS  = 6'd24;
  localparam logic [CAUSE_W-1:0] CAUSE_D_MULTI = 6'd25;
  localparam logic [CAUSE_W-1:0] CAUSE_D_PRIV  = 6'd26;

  localparam logic [VA_W-1:0] RASID_RESET = 32'h0403_0201;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [VPN_W-1:0]  ppn;
    logic [ASID_W-1:0] asid;
    logic [ATTR_W-1:0] attr;
  } tlb_entry_t;
endpackage

// File: rtl/ring_tlb_way.sv
module ring_tlb_way
  import ring_tlb_pkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  tlb_entry_t       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [VPN_W-1:0] rd_vpn,
  output logic             hit,
  output tlb_entry_t       rd_data
);
  tlb_entry_t mem_q [ENTRIES];
  tlb_entry_t mem_d [ENTRIES];

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) mem_d[i] = mem_q[i];
    if (wr_en) mem_d[wr_idx] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= mem_d[i];
    end
  end

  assign rd_data = mem_q[rd_idx];
  assign hit     = (rd_data.vpn == rd_vpn) && (rd_data.asid != '0);
endmodule

// File: rtl/ring_tlb_rasid.sv
module ring_tlb_rasid
  import ring_tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ra_wr,
  input  logic [VA_W-1:0]   ra_data,
  input  logic [1:0]        pte_sel,
  input  logic [ASID_W-1:0] hit_asid,
  output logic [VA_W-1:0]   rasid_q,
  output logic [ASID_W-1:0] sel_asid,
  output logic [1:0]        hit_ring
);
  logic [VA_W-1:0] rasid_d;
  logic            unused_low;

  assign unused_low = ^ra_data[ASID_W-1:0];

  always_comb begin
    rasid_d = rasid_q;
    if (ra_wr) rasid_d = {ra_data[VA_W-1:ASID_W], 8'h01};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rasid_q <= RASID_RESET;
    else if (ra_wr) rasid_q <= rasid_d;
  end

  assign sel_asid = rasid_q[{pte_sel, 3'b000} +: ASID_W];

  // lowest matching byte wins; no match leaves the least privileged ring
  always_comb begin
    hit_ring = 2'(RINGS - 1);
    for (int r = RINGS - 1; r >= 0; r--) begin
      if (rasid_q[r*ASID_W +: ASID_W] == hit_asid) hit_ring = 2'(r);
    end
  end

  // R2
  rasid_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ra_wr |=> (rasid_q == {$past(ra_data[VA_W-1:ASID_W]), 8'h01}));
endmodule

// File: rtl/ring_tlb_repl.sv
module ring_tlb_repl #(
  parameter int NWAYS = 4,
  localparam int WAY_W = $clog2(NWAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rf_fire,
  output logic [WAY_W-1:0] rf_way
);
  logic [WAY_W-1:0] cnt_q;
  logic [WAY_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (rf_fire) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (rf_fire) cnt_q <= cnt_d;
  end

  // pre-incremented: target is the value the counter is about to take
  assign rf_way = cnt_q + 1'b1;

  // R9
  repl_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_fire |=> (cnt_q == $past(rf_way)));
  // R12
  repl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rf_fire |=> $stable(cnt_q));
endmodule

// File: rtl/ring_tlb.sv
module ring_tlb
  import ring_tlb_pkg::*;
#(
  parameter int NWAYS   = 4,
  parameter int ENTRIES = 4,
  localparam int WAY_W  = $clog2(NWAYS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  input  logic [31:0]        lk_addr,
  input  logic [1:0]         lk_kind,
  input  logic [1:0]         lk_ring,
  input  logic               wr_en,
  input  logic [WAY_W-1:0]   wr_way,
  input  logic [31:0]        wr_addr,
  input  logic [31:0]        wr_pte,
  input  logic               ra_wr,
  input  logic [31:0]        ra_data,
  input  logic               rf_en,
  input  logic [31:0]        rf_addr,
  input  logic [31:0]        rf_pte,
  output logic [31:0]        ring_asid,
  output logic               rs_valid,
  output logic               rs_fault,
  output logic [5:0]         rs_cause,
  output logic [31:0]        rs_paddr,
  output logic [3:0]         rs_attr,
  output logic [31:0]        rs_probe
);
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int ENTRY_W = $bits(tlb_entry_t);

  // ---------------- write path selection ----------------
  logic             rf_fire;
  logic             any_wr;
  logic [WAY_W-1:0] rf_way;
  logic [WAY_W-1:0] tgt_way;
  logic [31:0]      tgt_addr;
  logic [31:0]      tgt_pte;
  logic [ASID_W-1:0] sel_asid;
  tlb_entry_t       new_entry;
  logic             unused_bits;

  assign rf_fire  = rf_en & ~wr_en;
  assign any_wr   = wr_en | rf_en;
  assign tgt_way  = wr_en ? wr_way  : rf_way;
  assign tgt_addr = wr_en ? wr_addr : rf_addr;
  assign tgt_pte  = wr_en ? wr_pte  : rf_pte;

  assign unused_bits = ^{tgt_addr[PAGE_BITS-1:0], tgt_pte[PAGE_BITS-1:6]};

  always_comb begin
    new_entry.vpn  = tgt_addr[VA_W-1:PAGE_BITS];
    new_entry.ppn  = tgt_pte[VA_W-1:PAGE_BITS];
    new_entry.asid = sel_asid;
    new_entry.attr = tgt_pte[ATTR_W-1:0];
  end

  // ---------------- ways ----------------
  logic [NWAYS-1:0] hit_vec;
  tlb_entry_t       way_data [NWAYS];

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    logic way_we;
    assign way_we = any_wr && (tgt_way == WAY_W'(w));
    ring_tlb_way #(.ENTRIES(ENTRIES)) u_way (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (way_we),
      .wr_idx  (tgt_addr[PAGE_BITS +: IDX_W]),
      .wr_data (new_entry),
      .rd_idx  (lk_addr[PAGE_BITS +: IDX_W]),
      .rd_vpn  (lk_addr[VA_W-1:PAGE_BITS]),
      .hit     (hit_vec[w]),
      .rd_data (way_data[w])
    );
  end

  // ---------------- hit merge ----------------
  tlb_entry_t       hit_entry;
  logic [WAY_W-1:0] hit_way;
  logic             no_hit;
  logic             multi_hit;
  logic [1:0]       hit_ring;

  always_comb begin
    hit_entry = '0;
    hit_way   = '0;
    for (int w = 0; w < NWAYS; w++) begin
      hit_entry = tlb_entry_t'(hit_entry | (way_data[w] & {ENTRY_W{hit_vec[w]}}));
      if (hit_vec[w]) hit_way = hit_way | WAY_W'(w);
    end
  end

  assign no_hit    = (hit_vec == '0);
  assign multi_hit = ((hit_vec & (hit_vec - 1'b1)) != '0);

  ring_tlb_rasid u_rasid (
    .clk      (clk),
    .rst_n    (rst_n),
    .ra_wr    (ra_wr),
    .ra_data  (ra_data),
    .pte_sel  (tgt_pte[5:4]),
    .hit_asid (hit_entry.asid),
    .rasid_q  (ring_asid),
    .sel_asid (sel_asid),
    .hit_ring (hit_ring)
  );

  ring_tlb_repl #(.NWAYS(NWAYS)) u_repl (
    .clk     (clk),
    .rst_n   (rst_n),
    .rf_fire (rf_fire),
    .rf_way  (rf_way)
  );

  // ---------------- result next-state ----------------
  logic        is_fetch;
  logic        fault_d;
  logic [5:0]  cause_d;
  logic [31:0] paddr_d;
  logic [3:0]  attr_d;
  logic [31:0] probe_d;

  assign is_fetch = (lk_kind == KIND_FETCH);

  always_comb begin
    fault_d = 1'b1;
    cause_d = '0;
    paddr_d = '0;
    attr_d  = '0;
    probe_d = '0;
    if (no_hit) begin
      cause_d = is_fetch ? CAUSE_I_MISS : CAUSE_D_MISS;
    end else if (multi_hit) begin
      cause_d = is_fetch ? CAUSE_I_MULTI : CAUSE_D_MULTI;
    end else if (hit_ring < lk_ring) begin
      cause_d = is_fetch ? CAUSE_I_PRIV : CAUSE_D_PRIV;
    end else begin
      fault_d = 1'b0;
      paddr_d = {hit_entry.ppn, lk_addr[PAGE_BITS-1:0]};
      attr_d  = hit_entry.attr;
      probe_d = {lk_addr[VA_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}}
              | 32'(hit_way) | (is_fetch ? 32'h8 : 32'h10);
    end
  end

  // ---------------- result registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_valid <= 1'b0;
    else        rs_valid <= lk_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_fault <= 1'b0;
      rs_cause <= '0;
      rs_paddr <= '0;
      rs_attr  <= '0;
      rs_probe <= '0;
    end else if (lk_valid) begin
      rs_fault <= fault_d;
      rs_cause <= cause_d;
      rs_paddr <= paddr_d;
      rs_attr  <= attr_d;
      rs_probe <= probe_d;
    end
  end

  // R4
  miss_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && hit_vec == '0) |=>
      (rs_fault && (rs_cause == CAUSE_I_MISS || rs_cause == CAUSE_D_MISS)));
  // R5
  multi_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !$onehot0(hit_vec)) |=>
      (rs_fault && (rs_cause == CAUSE_I_MULTI || rs_cause == CAUSE_D_MULTI)));
  // R11
  result_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rs_valid);
  // R11
  result_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rs_valid);
  // R7
  clean_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_fault) |-> (rs_cause == '0));
endmodule

// File: tb/ring_tlb_bench.sv
`timescale 1ns/1ps
module ring_tlb_bench;
  localparam int NW   = 4;
  localparam int NE   = 4;
  localparam int IDXW = 2;
  localparam int WW   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic [1:0]  lk_kind = '0;
  logic [1:0]  lk_ring = '0;
  logic wr_en = 1'b0;
  logic [WW-1:0] wr_way = '0;
  logic [31:0] wr_addr = '0, wr_pte = '0;
  logic ra_wr = 1'b0;
  logic [31:0] ra_data = '0;
  logic rf_en = 1'b0;
  logic [31:0] rf_addr = '0, rf_pte = '0;
  logic [31:0] ring_asid;
  logic rs_valid, rs_fault;
  logic [5:0] rs_cause;
  logic [31:0] rs_paddr, rs_probe;
  logic [3:0] rs_attr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ring_tlb #(.NWAYS(NW), .ENTRIES(NE)) u_ring_tlb (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_kind(lk_kind), .lk_ring(lk_ring),
    .wr_en(wr_en), .wr_way(wr_way), .wr_addr(wr_addr), .wr_pte(wr_pte),
    .ra_wr(ra_wr), .ra_data(ra_data),
    .rf_en(rf_en), .rf_addr(rf_addr), .rf_pte(rf_pte),
    .ring_asid(ring_asid), .rs_valid(rs_valid), .rs_fault(rs_fault),
    .rs_cause(rs_cause), .rs_paddr(rs_paddr), .rs_attr(rs_attr), .rs_probe(rs_probe)
  );

  // reference model
  logic [19:0] m_vpn  [NW][NE];
  logic [19:0] m_ppn  [NW][NE];
  logic [7:0]  m_asid [NW][NE];
  logic [3:0]  m_attr [NW][NE];
  logic [31:0] m_rasid;
  int          m_cnt;

  function automatic int m_ring(input logic [7:0] a);
    int r = 3;
    for (int i = 3; i >= 0; i--) if (m_rasid[i*8 +: 8] == a) r = i;
    return r;
  endfunction

  function automatic void m_put(input int w, input logic [31:0] a, input logic [31:0] p);
    int ix = int'(a[12 +: IDXW]);
    m_vpn[w][ix]  = a[31:12];
    m_ppn[w][ix]  = p[31:12];
    m_asid[w][ix] = m_rasid[{p[5:4], 3'b000} +: 8];
    m_attr[w][ix] = p[3:0];
  endfunction

  function automatic void m_look(input logic [31:0] a, input logic [1:0] k, input logic [1:0] r,
                                 output logic f, output logic [5:0] c, output logic [31:0] pa,
                                 output logic [3:0] at, output logic [31:0] pr);
    int ix = int'(a[12 +: IDXW]);
    int nh = 0;
    int hw = 0;
    logic fe = (k == 2'd2);
    for (int w = 0; w < NW; w++)
      if (m_vpn[w][ix] == a[31:12] && m_asid[w][ix] != 8'd0) begin nh++; hw = w; end
    f = 1'b1; c = 6'd0; pa = '0; at = '0; pr = '0;
    if (nh == 0)      c = fe ? 6'd16 : 6'd24;
    else if (nh > 1)  c = fe ? 6'd17 : 6'd25;
    else if (m_ring(m_asid[hw][ix]) < int'(r)) c = fe ? 6'd18 : 6'd26;
    else begin
      f  = 1'b0;
      pa = {m_ppn[hw][ix], a[11:0]};
      at = m_attr[hw][ix];
      pr = {a[31:12], 12'h0} | 32'(hw) | (fe ? 32'h8 : 32'h10);
    end
  endfunction

  task automatic check32(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic compare_result(input logic [31:0] a, input logic [1:0] k, input logic [1:0] r,
                                input logic ef, input logic [5:0] ec, input logic [31:0] epa,
                                input logic [3:0] eat, input logic [31:0] epr, input string req);
    checks++;
    if (rs_valid !== 1'b1 || rs_fault !== ef || rs_cause !== ec || rs_paddr !== epa ||
        rs_attr !== eat || rs_probe !== epr) begin
      errors++;
      $display("FAIL %s: addr %h kind %0d ring %0d actual v%b f%b c%0d pa %h at %h pr %h expected v1 f%b c%0d pa %h at %h pr %h",
               req, a, k, r, rs_valid, rs_fault, rs_cause, rs_paddr, rs_attr, rs_probe,
               ef, ec, epa, eat, epr);
    end
  endtask

  task automatic look(input logic [31:0] a, input logic [1:0] k, input logic [1:0] r, input string req);
    logic ef; logic [5:0] ec; logic [31:0] epa, epr; logic [3:0] eat;
    m_look(a, k, r, ef, ec, epa, eat, epr);
    lk_valid = 1'b1; lk_addr = a; lk_kind = k; lk_ring = r;
    @(negedge clk);
    lk_valid = 1'b0;
    compare_result(a, k, r, ef, ec, epa, eat, epr, req);
  endtask

  // lookup and write on the same edge
  task automatic look_wr(input logic [31:0] a, input int w, input logic [31:0] p, input string req);
    logic ef; logic [5:0] ec; logic [31:0] epa, epr; logic [3:0] eat;
    m_look(a, 2'd0, 2'd0, ef, ec, epa, eat, epr);
    lk_valid = 1'b1; lk_addr = a; lk_kind = 2'd0; lk_ring = 2'd0;
    wr_en = 1'b1; wr_way = WW'(w); wr_addr = a; wr_pte = p;
    @(negedge clk);
    lk_valid = 1'b0; wr_en = 1'b0;
    m_put(w, a, p);
    compare_result(a, 2'd0, 2'd0, ef, ec, epa, eat, epr, req);
  endtask

  task automatic do_write(input int w, input logic [31:0] a, input logic [31:0] p);
    wr_en = 1'b1; wr_way = WW'(w); wr_addr = a; wr_pte = p;
    @(negedge clk);
    wr_en = 1'b0;
    m_put(w, a, p);
  endtask

  task automatic do_refill(input logic [31:0] a, input logic [31:0] p);
    rf_en = 1'b1; rf_addr = a; rf_pte = p;
    @(negedge clk);
    rf_en = 1'b0;
    m_cnt = (m_cnt + 1) % NW;
    m_put(m_cnt, a, p);
  endtask

  task automatic do_both(input int w, input logic [31:0] a, input logic [31:0] p,
                         input logic [31:0] ra, input logic [31:0] rp);
    wr_en = 1'b1; wr_way = WW'(w); wr_addr = a; wr_pte = p;
    rf_en = 1'b1; rf_addr = ra; rf_pte = rp;
    @(negedge clk);
    wr_en = 1'b0; rf_en = 1'b0;
    m_put(w, a, p);
  endtask

  task automatic do_rasid(input logic [31:0] v);
    ra_wr = 1'b1; ra_data = v;
    @(negedge clk);
    ra_wr = 1'b0;
    m_rasid = {v[31:8], 8'h01};
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int w = 0; w < NW; w++)
      for (int i = 0; i < NE; i++) begin
        m_vpn[w][i] = '0; m_ppn[w][i] = '0; m_asid[w][i] = '0; m_attr[w][i] = '0;
      end
    m_rasid = 32'h0403_0201;
    m_cnt = 0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check32(ring_asid, 32'h0403_0201, "R1 ring register reset");
    check32({31'd0, rs_valid}, 32'd0, "R11 no result without request");
    look(32'h0000_0000, 2'd0, 2'd0, "R1 R4 empty buffer data miss");
    look(32'h1234_5abc, 2'd2, 2'd0, "R1 R4 empty buffer fetch miss");
    check32({26'd0, rs_cause}, 32'd16, "R4 fetch miss code");

    // R2: forced low byte
    do_rasid(32'hAABB_CCFF);
    check32(ring_asid, 32'hAABB_CC01, "R2 ring register write");

    // R8, R7, R10: explicit write, identifier from byte 2
    do_write(0, 32'h1234_5000, 32'h8765_4023);
    look(32'h1234_5abc, 2'd0, 2'd0, "R7 R8 hit ring 0");
    check32(rs_paddr, 32'h8765_4abc, "R7 physical address");
    check32(rs_probe, 32'h1234_5010, "R10 data probe word");
    look(32'h1234_5abc, 2'd2, 2'd1, "R10 fetch probe");
    check32(rs_probe, 32'h1234_5008, "R10 fetch probe word");
    look(32'h1234_5abc, 2'd1, 2'd2, "R6 equal ring allowed");
    look(32'h1234_5abc, 2'd0, 2'd3, "R6 data privilege fault");
    check32({26'd0, rs_cause}, 32'd26, "R6 data privilege code");
    look(32'h1234_5abc, 2'd2, 2'd3, "R6 fetch privilege fault");

    // R5: multi-hit
    do_write(2, 32'h1234_5000, 32'h1111_1013);
    look(32'h1234_5abc, 2'd1, 2'd0, "R5 data multi-hit");
    check32({26'd0, rs_cause}, 32'd25, "R5 data multi code");
    look(32'h1234_5abc, 2'd2, 2'd0, "R5 fetch multi-hit");
    do_write(2, 32'h9999_9000, 32'h2222_2010);
    look(32'h1234_5abc, 2'd0, 2'd0, "R5 single hit again");

    // R3: zero identifier never hits; same index different page misses
    do_rasid(32'h0000_0000);
    do_write(1, 32'h00AB_C000, 32'h3333_3010);
    look(32'h00AB_C123, 2'd0, 2'd0, "R3 zero identifier miss");
    look(32'h2222_5000, 2'd0, 2'd0, "R3 page mismatch miss");

    // R6: identifier no longer in register -> ring 3
    look(32'h1234_5abc, 2'd0, 2'd3, "R6 unmatched identifier ring 3");
    check32({31'd0, rs_fault}, 32'd0, "R6 unmatched no fault");

    // R9: round robin from reset value
    do_rasid(32'h0403_0201);
    do_refill(32'h4000_0000, 32'h5000_0005);
    look(32'h4000_0000, 2'd2, 2'd0, "R9 first refill");
    check32(rs_probe, 32'h4000_0009, "R9 first refill in way 1");
    do_refill(32'h4000_1000, 32'h5000_1005);
    look(32'h4000_1000, 2'd0, 2'd0, "R9 second refill");
    check32(rs_probe, 32'h4000_1012, "R9 second refill in way 2");
    do_refill(32'h4000_2000, 32'h5000_2005);
    look(32'h4000_2000, 2'd0, 2'd0, "R9 third refill");
    do_refill(32'h4000_3000, 32'h5000_3005);
    look(32'h4000_3000, 2'd0, 2'd0, "R9 fourth refill");
    check32(rs_probe, 32'h4000_3010, "R9 wrap to way 0");

    // R12: write port wins, counter holds
    do_both(3, 32'h6000_0000, 32'h7000_0001, 32'h6100_0000, 32'h7100_0001);
    look(32'h6000_0000, 2'd0, 2'd0, "R12 write port applied");
    look(32'h6100_0000, 2'd0, 2'd0, "R12 refill dropped");
    check32({31'd0, rs_fault}, 32'd1, "R12 dropped refill misses");
    do_refill(32'h6200_0000, 32'h7200_0001);
    look(32'h6200_0000, 2'd0, 2'd0, "R12 counter held");
    check32(rs_probe, 32'h6200_0011, "R12 next refill in way 1");

    // R11: same-edge write is not seen by the lookup
    look_wr(32'h6300_0000, 0, 32'h7300_0002, "R11 lookup sees old contents");
    look(32'h6300_0000, 2'd0, 2'd0, "R11 write visible next cycle");

    // random phase
    for (int n = 0; n < 600; n++) begin
      int op = $urandom_range(0, 9);
      logic [31:0] a = {20'h12340 + 20'($urandom_range(0, 9)), 12'($urandom)};
      logic [31:0] p = $urandom;
      if (op < 2)       do_write($urandom_range(0, NW-1), a, p);
      else if (op < 3)  do_refill(a, p);
      else if (op < 4)  do_rasid({8'($urandom_range(0, 5)), 8'($urandom_range(0, 5)),
                                  8'($urandom_range(0, 5)), 8'($urandom)});
      else              look(a, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                             "R3 R4 R5 R6 R7 R10 random lookup");
    end
    check32(ring_asid, m_rasid, "R2 ring register after random phase");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule